// File: doc/BRIEF.md
# Floating-point subnormal exception classifier

This unit sits beside a floating-point datapath and decides, for each operation, whether the hardware may carry on, must replace a tiny result with a signed zero, or must give up and raise an "unfinished" trap so that software completes the operation. It looks only at exponents and subnormal flags. It never looks at mantissas. Underflow is judged on the exponent before rounding. The unit does not round.

For each operation the caller presents these inputs: the operation class, the precision, both biased operand exponents, a subnormal flag for each operand, the pre-rounding result exponent (used by conversions and add/subtract) and the result sign. It also presents the non-standard (flush-to-zero) mode bit and the trap-enable mask. The unit computes the result exponent itself for multiply and divide. The decision, the current-exception flag updates and an IEEE trap request appear one cycle after the input strobe.

Operation codes on `op`: 0 float-to-integer, 1 format conversion (double-to-single), 2 square root, 3 add/subtract, 4 widening multiply, 5 multiply, 6 divide. Action codes on `action`: 0 proceed, 1 flush to signed zero, 2 unfinished trap. Flag bit positions in `trap_en` and `cexc` are: 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact. The lower window bound L is -25 for single precision and -54 for double. The bias B is 127 for single and 1023 for double. The overflow limit M is 255 for single and 2047 for double.

Top module: `fpsub_classifier`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle where `in_valid` is high, and low after a cycle where `in_valid` is low. The decision outputs change only with a strobe.
- R2: After a synchronous active-low reset, the outputs are in this state: `out_valid`=0, `action`=0, `cexc`=0, `ieee_trap`=0. `action` never takes the code 3.
- R3: The mode bit is low and the operation is float-to-integer, conversion or square root. If `sub_a` is set, the action is unfinished. `sub_b` has no effect on these operations.
- R4: The mode bit is low and the operation is add/subtract or widening multiply. If either operand is subnormal, the action is unfinished. For multiply and divide, if both operands are subnormal, the action is unfinished.
- R5: The mode bit is low, the operation is multiply or divide, and exactly one operand is subnormal. The action is unfinished when L < E_R < M. Otherwise the action is proceed.
- R6: For multiply, E_R = exp_a + exp_b - B + 1. For divide, E_R = exp_a - exp_b + B.
- R7: The mode bit is low and no operand trap applies. For add/subtract and conversion, the action is unfinished when L < `exp_res` < 1. A value of 1 or of L gives proceed.
- R8: The mode bit is low and no operand trap applies. For multiply and divide, the action is unfinished when L < E_R ≤ 1. The upper bound is included because the check is pessimistic.
- R9: The mode bit is high. For add/subtract, conversion, multiply and divide, a result exponent below 1 gives action flush, with `flush_sign` equal to `res_sign`. Operand subnormal flags are ignored in this mode.
- R10: On a flush, the flags follow the trap-enable mask. If underflow is enabled, `cexc`=00100 and `ieee_trap`=1. Otherwise, if inexact is enabled, `cexc`=00001 and `ieee_trap`=1. With neither enabled, `cexc`=00101 and `ieee_trap`=0.
- R11: Unfinished and proceed decisions carry `cexc`=0 and `ieee_trap`=0.
- R12: Square root, float-to-integer and widening multiply never take a result-exponent action, whatever the value of `exp_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| op | input | 3 | Operation class |
| is_double | input | 1 | 1 = double precision |
| exp_a | input | 11 | Biased exponent of operand A |
| exp_b | input | 11 | Biased exponent of operand B |
| sub_a | input | 1 | Operand A is subnormal |
| sub_b | input | 1 | Operand B is subnormal |
| exp_res | input | 14 | Signed pre-rounding result exponent (add/subtract, conversion) |
| res_sign | input | 1 | Sign of the result |
| ns_mode | input | 1 | Non-standard (flush-to-zero) mode |
| trap_en | input | 5 | Trap-enable mask |
| out_valid | output | 1 | Decision strobe |
| action | output | 2 | 0 proceed, 1 flush, 2 unfinished |
| flush_sign | output | 1 | Sign of the zero on a flush |
| cexc | output | 5 | Current-exception flag update |
| ieee_trap | output | 1 | IEEE trap request |

## Verification
The bench drives the window edges on both sides for each precision. For add/subtract it uses exponents 1, 0, L+1 and L. For multiply and divide it uses 2, 1, L+1 and L. A design with an off-by-one bound would trap at 1 for add or proceed at 1 for multiply. One-subnormal multiply and divide cases place E_R under L and above the overflow limit. A design missing either guard would trap where proceed is required. The bench also sets operand flags in flush mode, `sub_b` on single-operand operations, and very small `exp_res` on square root. A design that did not ignore these would trap or flush wrongly. Every combination of the trap-enable mask is applied to a flush, which exposes a wrong flag priority.

// File: rtl/fpsub_pkg.sv
// Shared encodings for the subnormal exception classifier.
// Assumes the flag ordering invalid/overflow/underflow/div-zero/inexact, MSB first.
package fpsub_pkg;
    typedef enum logic [2:0] {
        OP_TOINT = 3'd0,
        OP_CVT   = 3'd1,
        OP_SQRT  = 3'd2,
        OP_ADD   = 3'd3,
        OP_WMUL  = 3'd4,
        OP_MUL   = 3'd5,
        OP_DIV   = 3'd6
    } op_t;

    typedef enum logic [1:0] {
        ACT_PROCEED = 2'd0,
        ACT_FLUSH   = 2'd1,
        ACT_UNFIN   = 2'd2
    } act_t;

    localparam int FLAG_W = 5;
    localparam int FLG_NX = 0;
    localparam int FLG_DZ = 1;
    localparam int FLG_UF = 2;
    localparam int FLG_OF = 3;
    localparam int FLG_NV = 4;
endpackage

// File: rtl/fpsub_exp_calc.sv
// Result exponent estimate for multiply and divide from biased operand exponents.
// Assumes WORK_W holds 2*max_exp+1 as a positive signed value.
module fpsub_exp_calc #(
    parameter int EXP_W   = 11,
    parameter int WORK_W  = EXP_W + 3,
    parameter int SP_BIAS = 127,
    parameter int DP_BIAS = 1023
) (
    input  logic                     is_div,
    input  logic                     is_double,
    input  logic [EXP_W-1:0]         exp_a,
    input  logic [EXP_W-1:0]         exp_b,
    output logic signed [WORK_W-1:0] exp_est
);
    localparam logic signed [WORK_W-1:0] SP_B = WORK_W'(SP_BIAS);
    localparam logic signed [WORK_W-1:0] DP_B = WORK_W'(DP_BIAS);
    localparam logic signed [WORK_W-1:0] ONE  = WORK_W'(1);

    logic signed [WORK_W-1:0] ea, eb, bias;

    // Widen operands to the signed working width and pick the bias.
    always_comb begin
        ea   = $signed({{(WORK_W-EXP_W){1'b0}}, exp_a});
        eb   = $signed({{(WORK_W-EXP_W){1'b0}}, exp_b});
        bias = is_double ? DP_B : SP_B;
    end

    // Biased sum plus one for multiply, biased difference for divide.
    always_comb begin
        if (is_div) exp_est = ea - eb + bias;
        else        exp_est = ea + eb - bias + ONE;
    end
endmodule

// File: rtl/fpsub_window.sv
// Compares a signed exponent against the precision-dependent lower bound and 1.
// Assumes the bound values fit WORK_W.
module fpsub_window #(
    parameter int WORK_W = 14,
    parameter int SP_LO  = -25,
    parameter int DP_LO  = -54
) (
    input  logic                     is_double,
    input  logic                     incl_one,
    input  logic signed [WORK_W-1:0] exp_in,
    output logic                     above_lo,
    output logic                     below_one,
    output logic                     in_win
);
    localparam logic signed [WORK_W-1:0] SP_L = WORK_W'(SP_LO);
    localparam logic signed [WORK_W-1:0] DP_L = WORK_W'(DP_LO);
    localparam logic signed [WORK_W-1:0] ONE  = WORK_W'(1);

    // Evaluate both bounds; the upper bound is inclusive on request.
    always_comb begin
        above_lo  = exp_in > (is_double ? DP_L : SP_L);
        below_one = exp_in < ONE;
        in_win    = above_lo && (incl_one ? (exp_in <= ONE) : below_one);
    end
endmodule

// File: rtl/fpsub_classifier.sv
// Decides proceed / flush-to-zero / unfinished trap for one FP operation,
// plus flag updates and IEEE trap request, registered one cycle after in_valid.
// Assumes exponents are biased; exp_res is the pre-rounding signed exponent.
module fpsub_classifier #(
    parameter int EXP_W   = 11,
    parameter int WORK_W  = EXP_W + 3,
    parameter int SP_BIAS = 127,
    parameter int DP_BIAS = 1023,
    parameter int SP_EMAX = 255,
    parameter int DP_EMAX = 2047,
    parameter int SP_LO   = -25,
    parameter int DP_LO   = -54
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               op,
    input  logic                     is_double,
    input  logic [EXP_W-1:0]         exp_a,
    input  logic [EXP_W-1:0]         exp_b,
    input  logic                     sub_a,
    input  logic                     sub_b,
    input  logic signed [WORK_W-1:0] exp_res,
    input  logic                     res_sign,
    input  logic                     ns_mode,
    input  logic [4:0]               trap_en,
    output logic                     out_valid,
    output logic [1:0]               action,
    output logic                     flush_sign,
    output logic [4:0]               cexc,
    output logic                     ieee_trap
);
    import fpsub_pkg::*;

    localparam int NWIN = 2;
    localparam logic signed [WORK_W-1:0] SP_M = WORK_W'(SP_EMAX);
    localparam logic signed [WORK_W-1:0] DP_M = WORK_W'(DP_EMAX);

    op_t opc;
    logic is_md, single_op, res_op, ovf;
    logic signed [WORK_W-1:0] md_exp;
    logic signed [WORK_W-1:0] win_exp [NWIN];
    logic [NWIN-1:0] win_incl, win_above, win_below, win_in;
    logic opnd_unfin, res_unfin, do_flush;
    act_t act_d;
    logic [FLAG_W-1:0] cexc_d;
    logic trap_d;

    // Classify the operation code.
    always_comb begin
        opc       = op_t'(op);
        is_md     = (opc == OP_MUL) || (opc == OP_DIV);
        single_op = (opc == OP_TOINT) || (opc == OP_CVT) || (opc == OP_SQRT);
        res_op    = is_md || (opc == OP_ADD) || (opc == OP_CVT);
    end

    fpsub_exp_calc #(
        .EXP_W(EXP_W), .WORK_W(WORK_W), .SP_BIAS(SP_BIAS), .DP_BIAS(DP_BIAS)
    ) u_calc (
        .is_div(opc == OP_DIV), .is_double(is_double),
        .exp_a(exp_a), .exp_b(exp_b), .exp_est(md_exp)
    );

    // Window 0 checks the computed multiply/divide exponent, window 1 the supplied one.
    always_comb begin
        win_exp[0]  = md_exp;
        win_incl[0] = 1'b1;
        win_exp[1]  = exp_res;
        win_incl[1] = 1'b0;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        fpsub_window #(
            .WORK_W(WORK_W), .SP_LO(SP_LO), .DP_LO(DP_LO)
        ) u_win (
            .is_double(is_double), .incl_one(win_incl[w]), .exp_in(win_exp[w]),
            .above_lo(win_above[w]), .below_one(win_below[w]), .in_win(win_in[w])
        );
    end

    // Overflow guard for the one-subnormal multiply/divide case.
    always_comb ovf = md_exp >= (is_double ? DP_M : SP_M);

    // Operand-subnormal and result-subnormal trap conditions, and flush condition.
    always_comb begin
        opnd_unfin = 1'b0;
        if (single_op)
            opnd_unfin = sub_a;
        else if ((opc == OP_ADD) || (opc == OP_WMUL))
            opnd_unfin = sub_a | sub_b;
        else if (is_md)
            opnd_unfin = (sub_a & sub_b) | ((sub_a ^ sub_b) & ~ovf & win_above[0]);
        res_unfin = res_op && (is_md ? win_in[0] : win_in[1]);
        do_flush  = res_op && (is_md ? win_below[0] : win_below[1]);
    end

    // Combine with priority: mode, then operand rule, then result rule.
    always_comb begin
        act_d  = ACT_PROCEED;
        cexc_d = '0;
        trap_d = 1'b0;
        if (ns_mode) begin
            if (do_flush) begin
                act_d = ACT_FLUSH;
                if (trap_en[FLG_UF]) begin
                    cexc_d[FLG_UF] = 1'b1;
                    trap_d         = 1'b1;
                end else if (trap_en[FLG_NX]) begin
                    cexc_d[FLG_NX] = 1'b1;
                    trap_d         = 1'b1;
                end else begin
                    cexc_d[FLG_UF] = 1'b1;
                    cexc_d[FLG_NX] = 1'b1;
                end
            end
        end else if (opnd_unfin || res_unfin) begin
            act_d = ACT_UNFIN;
        end
    end

    // Register the decision on each strobe; the valid flag tracks the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            action     <= ACT_PROCEED;
            flush_sign <= 1'b0;
            cexc       <= '0;
            ieee_trap  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                action     <= act_d;
                flush_sign <= res_sign;
                cexc       <= cexc_d;
                ieee_trap  <= trap_d;
            end
        end
    end
endmodule

// File: rtl/fpsub_classifier_chk.sv
// Protocol and flag-consistency properties for the classifier outputs.
// Assumes it is bound into fpsub_classifier and sees its ports.
module fpsub_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       ns_mode,
    input logic       out_valid,
    input logic [1:0] action,
    input logic [4:0] cexc,
    input logic       ieee_trap
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_action_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        action != 2'd3);
    assert_flush_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && action == 2'd1) |-> $past(ns_mode));
    assert_flush_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && action == 2'd1) |-> ((cexc[2] | cexc[0]) && (cexc & 5'b11010) == 5'd0));
    assert_trap_only_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ieee_trap |-> action == 2'd1);
    assert_quiet_unfinished_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && action == 2'd2) |-> (cexc == 5'd0 && !ieee_trap));
endmodule

bind fpsub_classifier fpsub_classifier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ns_mode(ns_mode),
    .out_valid(out_valid), .action(action), .cexc(cexc), .ieee_trap(ieee_trap)
);

// File: tb/fpsub_classifier_test.sv
module fpsub_classifier_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] PRO = 2'd0, FLU = 2'd1, UNF = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [2:0] op = '0;
    logic is_double = 1'b0;
    logic [10:0] exp_a = '0, exp_b = '0;
    logic sub_a = 1'b0, sub_b = 1'b0;
    logic signed [13:0] exp_res = '0;
    logic res_sign = 1'b0, ns_mode = 1'b0;
    logic [4:0] trap_en = '0;
    logic out_valid, flush_sign, ieee_trap;
    logic [1:0] action;
    logic [4:0] cexc;
    int checks = 0, errors = 0;

    fpsub_classifier uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample after the registering edge.
    task automatic run(string req, int o, bit dp, int ea, int eb, bit sa, bit sb,
                       int er, bit ns, bit [4:0] te, bit sg,
                       logic [1:0] e_act, logic [4:0] e_cexc, bit e_trap);
        @(negedge clk);
        in_valid = 1'b1; op = 3'(o); is_double = dp; exp_a = 11'(ea); exp_b = 11'(eb);
        sub_a = sa; sub_b = sb; exp_res = 14'(er); ns_mode = ns; trap_en = te; res_sign = sg;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " action"}, int'(action), int'(e_act));
        check({req, " cexc"}, int'(cexc), int'(e_cexc));
        check({req, " trap"}, int'(ieee_trap), int'(e_trap));
        if (e_act == FLU) check({req, " sign"}, int'(flush_sign), int'(sg));
    endtask

    task automatic t_reset();
        check("R2 valid", int'(out_valid), 0);
        check("R2 action", int'(action), 0);
        check("R2 cexc", int'(cexc), 0);
        check("R2 trap", int'(ieee_trap), 0);
    endtask

    task automatic t_strobe();
        run("R1", 3, 0, 0, 0, 0, 0, 0, 1, 5'b00100, 1, FLU, 5'b00100, 1);
        @(negedge clk);
        check("R1 drop", int'(out_valid), 0);
        check("R1 hold", int'(action), int'(FLU));
    endtask

    task automatic t_single_op();
        run("R3 toint a", 0, 0, 0, 0, 1, 0, 50, 0, 0, 0, UNF, 0, 0);
        run("R3 toint b", 0, 0, 0, 0, 0, 1, 50, 0, 0, 0, PRO, 0, 0);
        run("R3 sqrt a", 2, 1, 0, 0, 1, 0, 50, 0, 0, 0, UNF, 0, 0);
        run("R3 cvt a", 1, 1, 0, 0, 1, 0, 50, 0, 0, 0, UNF, 0, 0);
    endtask

    task automatic t_multi_sub();
        run("R4 add b", 3, 0, 100, 0, 0, 1, 50, 0, 0, 0, UNF, 0, 0);
        run("R4 wmul a", 4, 0, 0, 100, 1, 0, 50, 0, 0, 0, UNF, 0, 0);
        run("R4 mul both", 5, 0, 0, 0, 1, 1, 50, 0, 0, 0, UNF, 0, 0);
        run("R4 div both", 6, 1, 0, 0, 1, 1, 50, 0, 0, 0, UNF, 0, 0);
    endtask

    task automatic t_one_sub_md();
        run("R5 mul in", 5, 0, 0, 200, 1, 0, 0, 0, 0, 0, UNF, 0, 0);   // E_R=74
        run("R5 mul low", 5, 0, 0, 100, 1, 0, 0, 0, 0, 0, PRO, 0, 0);  // E_R=-26
        run("R5 mul lo+1", 5, 0, 0, 102, 1, 0, 0, 0, 0, 0, UNF, 0, 0); // E_R=-24
        run("R5 div ovf", 6, 0, 250, 0, 0, 1, 0, 0, 0, 0, PRO, 0, 0);  // E_R=377
        run("R5 div dp ovf", 6, 1, 1500, 400, 0, 1, 0, 0, 0, 0, PRO, 0, 0); // 2123
        run("R5 div dp in", 6, 1, 1000, 400, 0, 1, 0, 0, 0, 0, UNF, 0, 0);  // 1623
    endtask

    task automatic t_add_window();
        run("R7 sp one", 3, 0, 9, 9, 0, 0, 1, 0, 0, 0, PRO, 0, 0);
        run("R7 sp zero", 3, 0, 9, 9, 0, 0, 0, 0, 0, 0, UNF, 0, 0);
        run("R7 sp lo+1", 3, 0, 9, 9, 0, 0, -24, 0, 0, 0, UNF, 0, 0);
        run("R7 sp lo", 3, 0, 9, 9, 0, 0, -25, 0, 0, 0, PRO, 0, 0);
        run("R7 dp lo+1", 1, 1, 9, 9, 0, 0, -53, 0, 0, 0, UNF, 0, 0);
        run("R7 dp lo", 3, 1, 9, 9, 0, 0, -54, 0, 0, 0, PRO, 0, 0);
    endtask

    task automatic t_md_window();
        run("R8 R6 mul 2", 5, 0, 63, 65, 0, 0, 0, 0, 0, 0, PRO, 0, 0);
        run("R8 R6 mul 1", 5, 0, 63, 64, 0, 0, 0, 0, 0, 0, UNF, 0, 0);
        run("R8 R6 mul lo+1", 5, 0, 51, 51, 0, 0, 0, 0, 0, 0, UNF, 0, 0);
        run("R8 R6 mul lo", 5, 0, 51, 50, 0, 0, 0, 0, 0, 0, PRO, 0, 0);
        run("R8 R6 div 1", 6, 0, 10, 136, 0, 0, 0, 0, 0, 0, UNF, 0, 0);
        run("R8 R6 div 2", 6, 0, 10, 135, 0, 0, 0, 0, 0, 0, PRO, 0, 0);
        run("R8 R6 dp mul in", 5, 1, 500, 500, 0, 0, 0, 0, 0, 0, UNF, 0, 0); // -22
        run("R8 R6 dp mul lo", 5, 1, 485, 483, 0, 0, 0, 0, 0, 0, PRO, 0, 0); // -54
        run("R8 R6 dp div lo+1", 6, 1, 100, 1176, 0, 0, 0, 0, 0, 0, UNF, 0, 0); // -53
    endtask

    task automatic t_flush();
        run("R9 add flush", 3, 0, 9, 9, 0, 0, -5, 1, 5'b00000, 1, FLU, 5'b00101, 0);
        run("R9 ignore sub", 3, 0, 9, 9, 1, 1, 5, 1, 5'b00000, 0, PRO, 0, 0);
        run("R9 mul one", 5, 0, 63, 64, 0, 0, 0, 1, 5'b00000, 1, PRO, 0, 0);
        run("R9 mul deep", 5, 0, 10, 10, 1, 0, 0, 1, 5'b00000, 0, FLU, 5'b00101, 0);
        run("R9 div", 6, 1, 10, 1100, 0, 0, 0, 1, 5'b00000, 1, FLU, 5'b00101, 0);
    endtask

    task automatic t_flags();
        run("R10 uf", 3, 0, 9, 9, 0, 0, -3, 1, 5'b00100, 0, FLU, 5'b00100, 1);
        run("R10 nx", 3, 0, 9, 9, 0, 0, -3, 1, 5'b00001, 1, FLU, 5'b00001, 1);
        run("R10 both", 3, 0, 9, 9, 0, 0, -3, 1, 5'b00101, 0, FLU, 5'b00100, 1);
        run("R10 others", 3, 0, 9, 9, 0, 0, -3, 1, 5'b11010, 1, FLU, 5'b00101, 0);
    endtask

    task automatic t_quiet();
        run("R11 unfin", 3, 0, 9, 9, 0, 0, 0, 0, 5'b11111, 0, UNF, 0, 0);
        run("R11 proceed", 3, 0, 9, 9, 0, 0, 20, 0, 5'b11111, 0, PRO, 0, 0);
    endtask

    task automatic t_no_result_ops();
        run("R12 sqrt", 2, 0, 9, 9, 0, 0, -5, 0, 0, 0, PRO, 0, 0);
        run("R12 wmul", 4, 0, 9, 9, 0, 0, -5, 0, 0, 0, PRO, 0, 0);
        run("R12 toint ns", 0, 1, 9, 9, 0, 0, -5, 1, 5'b00100, 0, PRO, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_strobe();
        t_single_op();
        t_multi_sub();
        t_one_sub_md();
        t_add_window();
        t_md_window();
        t_flush();
        t_flags();
        t_quiet();
        t_no_result_ops();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule